// File: doc/BRIEF.md
# Grouped Vectored Interrupt Controller

This block collects interrupt requests for a small microcontroller core and turns them into one vectored request at a time. Four sources have a dedicated request flag each: a comparator, an A/D converter that signals the end of a conversion, and two periodic time-base timers. Three further grouped channels each merge several sub-source flags, for example timers, a low-voltage detector or a non-volatile memory write-done event. A grouped channel holds its own group flag, separate from the flags of its members.

A pending flag becomes a candidate only when its own enable bit is set, the global enable bit is set and the core reports that its call stack has room. The lowest-numbered candidate wins. The block then presents its vector index on a valid/ready style pair (`irq_valid` / `irq_ack`). Once `irq_valid` is high, the index is held and cannot be replaced until the core raises `irq_ack` in a cycle where `irq_valid` is high. That handshake clears the serviced flag and the global enable bit. Software reaches every flag and enable through a simple register port: writes take effect at the next edge and reads are combinational.

Top module: `gvic_top`

## Requirements
- R1: The comparator flag (pending bit 0) is set one clock after `cmp_out` changes level, on a rising change and on a falling change alike.
- R2: A one-cycle `adc_done` pulse sets pending bit 1. A pulse on `tb_ovf[0]` sets pending bit 2 and a pulse on `tb_ovf[1]` sets pending bit 3, in each case at the next edge.
- R3: `irq_valid` rises only if, in the cycle before, the global enable (bit 7 of register 0) was 1 and at least one pending bit had its enable bit (bit i of register 0) set. With the global enable at 0, no request is raised.
- R4: When several enabled flags are pending, the vector chosen is the lowest set index. Vector indices are: 0 comparator, 1 A/D, 2 and 3 time bases, 4+g group g. Flags that lose the choice stay pending.
- R5: While `irq_valid` is high and `irq_ack` is low, `irq_valid` stays high and `irq_vec` does not change, even if new flags arrive.
- R6: A handshake (`irq_valid` and `irq_ack` high together) clears the pending bit of the served vector and the global enable. `irq_valid` is low in the following cycle.
- R7: A rising sub-source flag of group g (register 2, bit 4g+k) sets pending bit 4+g in the same edge. Serving vector 4+g leaves all register 2 bits unchanged.
- R8: After a group flag is served, it is set again only when one of its sub-source flags goes from 0 to 1. A sub-source event on a member flag that is already set does not set it again.
- R9: Writing register 0 (enables), 1 (pending) or 2 (sub-sources) loads the full value. A hardware set event in the same cycle as a software write of 0 leaves that flag set.
- R10: Writing the global enable back to 1 while an enabled flag is still pending raises `irq_valid` one cycle after the write takes effect.
- R11: While `stack_ok` is low, `irq_valid` does not rise. It rises one cycle after `stack_ok` returns high if an enabled flag is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| cmp_out | input | 1 | Comparator output level |
| adc_done | input | 1 | End-of-conversion pulse |
| tb_ovf | input | NUM_TB (2) | Time-base overflow pulses |
| sub_evt | input | NUM_GRP*SUB_W (12) | Sub-source set pulses, group g at bits 4g..4g+3 |
| stack_ok | input | 1 | Core call stack is not full |
| irq_valid | output | 1 | Vector request valid |
| irq_vec | output | VEC_W (3) | Vector index of the request |
| irq_ack | input | 1 | Core accepts the request (ready) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Write address: 0 enables, 1 pending, 2 sub-sources |
| reg_wr_data | input | RW_W (12) | Write data |
| reg_rd_addr | input | 2 | Read address, same map |
| reg_rd_data | output | RW_W (12) | Combinational read data |

## Verification
A flag that is stuck or lost shows up in the pending register read one edge after the event, and as a missing or extra `irq_valid` one edge after that. A fault in the priority or gating logic shows up as a wrong `irq_vec` or a missing request, which becomes visible at the second edge after the enables and flags are loaded. A group channel that retriggers when it should not, or that clears its members, shows up in the pending or sub-source read directly after the sub-source pulse or the handshake.

// File: rtl/gvic_pkg.sv
package gvic_pkg;
  // register port address map
  typedef enum logic [1:0] {
    RA_ENABLE = 2'd0,
    RA_PEND   = 2'd1,
    RA_SUB    = 2'd2,
    RA_NONE   = 2'd3
  } reg_addr_e;

  // dedicated sources besides the time bases: comparator and A/D
  localparam int unsigned NUM_FIXED = 2;
endpackage

// File: rtl/gvic_src_flags.sv
module gvic_src_flags #(
  parameter int unsigned NUM_TB = 2,
  localparam int unsigned NIND = gvic_pkg::NUM_FIXED + NUM_TB
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmp_out,
  input  logic            adc_done,
  input  logic [NUM_TB-1:0] tb_ovf,
  input  logic            wr_en,
  input  logic [NIND-1:0] wr_val,
  input  logic [NIND-1:0] clr,
  output logic [NIND-1:0] flags
);
  logic            cmp_q;
  logic [NIND-1:0] set_evt;
  logic [NIND-1:0] flags_d;

  assign set_evt = {tb_ovf, adc_done, cmp_out ^ cmp_q};

  always_comb begin
    flags_d = ((wr_en ? wr_val : flags) & ~clr) | set_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= 1'b0;
      flags <= '0;
    end else begin
      cmp_q <= cmp_out;
      flags <= flags_d;
    end
  end

  // hardware set events survive any software write or service clear
  assert_hw_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt != '0) |=> ((flags & $past(set_evt)) == $past(set_evt)));

  // a comparator level change always lands in the flag
  assert_cmp_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_out != cmp_q) |=> flags[0]);
endmodule

// File: rtl/gvic_group_chan.sv
module gvic_group_chan #(
  parameter int unsigned SUB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SUB_W-1:0] sub_evt,
  input  logic             sub_wr,
  input  logic [SUB_W-1:0] sub_wdata,
  input  logic             grp_wr,
  input  logic             grp_wdata,
  input  logic             grp_clr,
  output logic [SUB_W-1:0] sub_flags,
  output logic             grp_flag
);
  logic [SUB_W-1:0] sub_d;
  logic             member_rise;
  logic             grp_d;

  always_comb begin
    sub_d       = sub_evt | (sub_wr ? sub_wdata : sub_flags);
    member_rise = |(sub_d & ~sub_flags);
    grp_d       = member_rise | ((grp_wr ? grp_wdata : grp_flag) & ~grp_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_flags <= '0;
      grp_flag  <= 1'b0;
    end else begin
      sub_flags <= sub_d;
      grp_flag  <= grp_d;
    end
  end

  // servicing the group never touches the member flags
  assert_members_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_clr && !sub_wr && sub_evt == '0) |=> (sub_flags == $past(sub_flags)));

  // a served group stays clear when no member goes 0 -> 1
  assert_no_retrigger_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_clr && !grp_wr && !sub_wr && ((sub_evt & ~sub_flags) == '0)) |=> !grp_flag);
endmodule

// File: rtl/gvic_arbiter.sv
module gvic_arbiter #(
  parameter int unsigned NSRC = 7,
  localparam int unsigned VEC_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  cand,
  input  logic             ack,
  output logic             valid,
  output logic [VEC_W-1:0] vec,
  output logic [NSRC-1:0]  clr_vec,
  output logic             fire
);
  function automatic logic [VEC_W-1:0] pick_low(input logic [NSRC-1:0] c);
    pick_low = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (c[i]) pick_low = VEC_W'(i);
    end
  endfunction

  logic [NSRC-1:0] low_mask;

  assign fire     = valid & ack;
  assign clr_vec  = fire ? (NSRC'(1) << vec) : '0;
  assign low_mask = (NSRC'(1) << vec) - NSRC'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      vec   <= '0;
    end else if (valid) begin
      if (ack) valid <= 1'b0;
    end else if (|cand) begin
      valid <= 1'b1;
      vec   <= pick_low(cand);
    end
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ack) |=> (valid && $stable(vec)));

  assert_prio_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> (($past(cand) & low_mask) == '0));

  assert_clr_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_vec));

  assert_drop_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !valid);
endmodule

// File: rtl/gvic_top.sv
module gvic_top #(
  parameter int unsigned NUM_TB  = 2,
  parameter int unsigned NUM_GRP = 3,
  parameter int unsigned SUB_W   = 4,
  localparam int unsigned NIND  = gvic_pkg::NUM_FIXED + NUM_TB,
  localparam int unsigned NSRC  = NIND + NUM_GRP,
  localparam int unsigned VEC_W = $clog2(NSRC),
  localparam int unsigned NSUB  = NUM_GRP * SUB_W,
  localparam int unsigned RW_W  = (NSRC + 1 > NSUB) ? NSRC + 1 : NSUB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_out,
  input  logic              adc_done,
  input  logic [NUM_TB-1:0] tb_ovf,
  input  logic [NSUB-1:0]   sub_evt,
  input  logic              stack_ok,
  output logic              irq_valid,
  output logic [VEC_W-1:0]  irq_vec,
  input  logic              irq_ack,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_wr_addr,
  input  logic [RW_W-1:0]   reg_wr_data,
  input  logic [1:0]        reg_rd_addr,
  output logic [RW_W-1:0]   reg_rd_data
);
  import gvic_pkg::*;

  logic [NSRC-1:0] en_q;
  logic            gie_q;
  logic [NSRC-1:0] pend;
  logic [NSUB-1:0] sub_all;
  logic [NSRC-1:0] cand;
  logic [NSRC-1:0] clr_vec;
  logic            fire;
  logic            wr_en_reg, wr_pend, wr_sub;

  assign wr_en_reg = reg_wr_en && (reg_addr_e'(reg_wr_addr) == RA_ENABLE);
  assign wr_pend   = reg_wr_en && (reg_addr_e'(reg_wr_addr) == RA_PEND);
  assign wr_sub    = reg_wr_en && (reg_addr_e'(reg_wr_addr) == RA_SUB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      gie_q <= 1'b0;
    end else begin
      if (wr_en_reg) begin
        en_q  <= reg_wr_data[NSRC-1:0];
        gie_q <= reg_wr_data[NSRC];
      end
      if (fire) gie_q <= 1'b0;
    end
  end

  gvic_src_flags #(.NUM_TB(NUM_TB)) u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmp_out  (cmp_out),
    .adc_done (adc_done),
    .tb_ovf   (tb_ovf),
    .wr_en    (wr_pend),
    .wr_val   (reg_wr_data[NIND-1:0]),
    .clr      (clr_vec[NIND-1:0]),
    .flags    (pend[NIND-1:0])
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    gvic_group_chan #(.SUB_W(SUB_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .sub_evt   (sub_evt[g*SUB_W +: SUB_W]),
      .sub_wr    (wr_sub),
      .sub_wdata (reg_wr_data[g*SUB_W +: SUB_W]),
      .grp_wr    (wr_pend),
      .grp_wdata (reg_wr_data[NIND+g]),
      .grp_clr   (clr_vec[NIND+g]),
      .sub_flags (sub_all[g*SUB_W +: SUB_W]),
      .grp_flag  (pend[NIND+g])
    );
  end

  assign cand = pend & en_q & {NSRC{gie_q & stack_ok}};

  gvic_arbiter #(.NSRC(NSRC)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .cand    (cand),
    .ack     (irq_ack),
    .valid   (irq_valid),
    .vec     (irq_vec),
    .clr_vec (clr_vec),
    .fire    (fire)
  );

  always_comb begin
    reg_rd_data = '0;
    case (reg_addr_e'(reg_rd_addr))
      RA_ENABLE: begin
        reg_rd_data[NSRC-1:0] = en_q;
        reg_rd_data[NSRC]     = gie_q;
      end
      RA_PEND:   reg_rd_data[NSRC-1:0] = pend;
      RA_SUB:    reg_rd_data[NSUB-1:0] = sub_all;
      default:   reg_rd_data = '0;
    endcase
  end

  assert_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) |-> $past(gie_q && ((pend & en_q) != '0)));

  assert_stack_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) |-> $past(stack_ok));

  assert_gie_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ack) |=> !gie_q);
endmodule

// File: tb/gvic_top_tb_top.sv
module gvic_top_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_out = 1'b0, adc_done = 1'b0, stack_ok = 1'b1, irq_ack = 1'b0;
  logic [1:0]  tb_ovf = '0;
  logic [11:0] sub_evt = '0;
  logic        irq_valid;
  logic [2:0]  irq_vec;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_wr_addr = '0, reg_rd_addr = '0;
  logic [11:0] reg_wr_data = '0;
  logic [11:0] reg_rd_data;

  int errors = 0;
  int checks = 0;

  always #(CLK_P/2) clk = ~clk;

  gvic_top dut_i (
    .clk(clk), .rst_n(rst_n), .cmp_out(cmp_out), .adc_done(adc_done),
    .tb_ovf(tb_ovf), .sub_evt(sub_evt), .stack_ok(stack_ok),
    .irq_valid(irq_valid), .irq_vec(irq_vec), .irq_ack(irq_ack),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    reg_rd_addr = a;
    #1;
    v = int'(reg_rd_data);
  endtask

  task automatic wr(input logic [1:0] a, input logic [11:0] d);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    step();
    reg_wr_en = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1;
    step();
    irq_ack = 1'b0;
  endtask

  task automatic clean();
    wr(2'd2, 12'h000);
    wr(2'd1, 12'h000);
    wr(2'd0, 12'h000);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v;
    int exp_v;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // reset state
    chk("R6 reset valid", int'(irq_valid), 0);
    rd(2'd0, v); chk("R9 reset enables", v, 0);
    rd(2'd1, v); chk("R9 reset pending", v, 0);
    rd(2'd2, v); chk("R7 reset subs", v, 0);

    // R2 A/D and time base flags
    adc_done = 1'b1; step(); adc_done = 1'b0;
    rd(2'd1, v); chk("R2 adc flag", v, 12'h002);
    tb_ovf = 2'b01; step(); tb_ovf = 2'b00;
    rd(2'd1, v); chk("R2 tb0 flag", v, 12'h006);
    tb_ovf = 2'b10; step(); tb_ovf = 2'b00;
    rd(2'd1, v); chk("R2 tb1 flag", v, 12'h00E);
    chk("R3 no request with enables off", int'(irq_valid), 0);
    clean();

    // R9 hardware set beats software clear in the same cycle
    reg_wr_en = 1'b1; reg_wr_addr = 2'd1; reg_wr_data = 12'h000; adc_done = 1'b1;
    step();
    reg_wr_en = 1'b0; adc_done = 1'b0;
    rd(2'd1, v); chk("R9 hw set over sw clear", v, 12'h002);
    wr(2'd1, 12'h050);
    rd(2'd1, v); chk("R9 sw load pending", v, 12'h050);
    clean();

    // R3 global enable off blocks everything
    wr(2'd0, 12'h07F);
    wr(2'd1, 12'h07F);
    step(); step();
    chk("R3 gie off no request", int'(irq_valid), 0);
    clean();

    // R4/R6 sweep over every enable mask with all flags pending
    for (int m = 1; m < 128; m++) begin
      exp_v = 0;
      for (int b = 6; b >= 0; b--) if (m[b]) exp_v = b;
      wr(2'd0, 12'(m | 'h80));
      wr(2'd1, 12'h07F);
      step();
      chk("R4 sweep valid", int'(irq_valid), 1);
      chk("R4 sweep vector", int'(irq_vec), exp_v);
      ack();
      chk("R6 sweep drop", int'(irq_valid), 0);
      rd(2'd1, v); chk("R6 sweep flag cleared, others pending", v, 'h7F & ~(1 << exp_v));
      rd(2'd0, v); chk("R6 sweep gie cleared", v, m);
      clean();
    end

    // R5 hold, R1 rising edge, R10 re-enable
    wr(2'd0, 12'h083);
    adc_done = 1'b1; step(); adc_done = 1'b0;
    step();
    chk("R5 initial vector", int'(irq_vec), 1);
    cmp_out = 1'b1; step(); step(); step();
    chk("R5 held valid", int'(irq_valid), 1);
    chk("R5 held vector", int'(irq_vec), 1);
    ack();
    chk("R6 drop after ack", int'(irq_valid), 0);
    rd(2'd1, v); chk("R1 rising edge flag pending", v, 12'h001);
    step();
    chk("R6 no request while gie off", int'(irq_valid), 0);
    wr(2'd0, 12'h083);
    step();
    chk("R10 re-enable valid", int'(irq_valid), 1);
    chk("R10 re-enable vector", int'(irq_vec), 0);
    ack();
    clean();
    cmp_out = 1'b0; step();
    rd(2'd1, v); chk("R1 falling edge flag", v, 12'h001);
    clean();

    // R11 stack full suppresses requests
    stack_ok = 1'b0;
    wr(2'd0, 12'h082);
    adc_done = 1'b1; step(); adc_done = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R11 stack full no request", int'(irq_valid), 0);
    end
    stack_ok = 1'b1;
    step();
    chk("R11 stack free valid", int'(irq_valid), 1);
    chk("R11 stack free vector", int'(irq_vec), 1);
    ack();
    clean();

    // R7/R8 grouped channel 1 (vector 5), members at bits 4..7
    wr(2'd0, 12'h0A0);
    sub_evt = 12'h040; step(); sub_evt = '0;
    rd(2'd2, v); chk("R7 member flag set", v, 12'h040);
    rd(2'd1, v); chk("R7 group flag set", v, 12'h020);
    step();
    chk("R7 group vector", int'(irq_vec), 5);
    ack();
    rd(2'd1, v); chk("R7 group flag served", v, 12'h000);
    rd(2'd2, v); chk("R7 members kept", v, 12'h040);
    sub_evt = 12'h040; step(); sub_evt = '0;
    step(); step();
    rd(2'd1, v); chk("R8 no retrigger from set member", v, 12'h000);
    sub_evt = 12'h080; step(); sub_evt = '0;
    rd(2'd1, v); chk("R8 new rising member", v, 12'h020);
    rd(2'd2, v); chk("R8 member flags", v, 12'h0C0);
    wr(2'd2, 12'h000);
    wr(2'd1, 12'h000);
    sub_evt = 12'h040; step(); sub_evt = '0;
    rd(2'd1, v); chk("R8 rising after sw clear", v, 12'h020);
    clean();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule